// File: doc/BRIEF.md
# SPI Serial Byte-RAM Target

This block is the target side of a serial peripheral link that fronts a small byte-addressed RAM with the command set of a serial EERAM. The host drops chip select to open a frame and clocks in a one-byte command. Where the command needs an address, two address bytes follow, high byte first. Data bytes then stream in or out. When chip select rises, the frame is closed. A status byte holds a write-enable latch, a set of stored option bits, and a page-rollover bit that confines streaming to 32-byte pages.

All link pins are brought into the system clock domain through two-flop synchronizers. Link edges are found from the synchronized serial clock, so the serial clock must run well below the system clock. At the default of at least six system clocks per serial half period, timing is comfortable. The array holds `2**ARR_AW` bytes. Setting `ARR_AW = 13` gives the full 8 KiB. The default of 11 keeps elaboration small.

The write-enable latch protects the array and the status byte. A write or status-write frame is acted on only if the latch was set when its command byte arrived. When such a frame ends, the latch clears by itself. A host can poll the status byte to see that its write has completed.

Top module: `sram_spi_target`

## Requirements
- R1: After reset, the status byte reads 0x00, and MISO is held low whenever chip select is high.
- R2: Command 0x05 returns the status byte, MSB first, on every byte that follows it in the frame. The status byte has: bit0 busy (always 0), bit1 the write-enable latch, bits 2 to 6 the stored option bits, and bit7 always 0.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it. Each takes effect when its command byte completes.
- R4: Command 0x02 is followed by address high, address low, then data bytes. Data is written only if the latch was set at the command byte; otherwise the frame changes nothing. The address is masked to ARR_AW bits.
- R5: When chip select rises after an accepted write or status-write frame, the write-enable latch reads 0.
- R6: Command 0x03 is followed by two address bytes. The target then returns the stored bytes starting at that address, MSB first. It uses mode 0: the host samples on the rising edge and MISO changes on the falling edge.
- R7: With status bit5 (page rollover) set, a streamed address advances only its low 5 bits and wraps inside its 32-byte page.
- R8: With bit5 clear, a streamed address advances through the whole array and wraps from the last byte to 0.
- R9: Command 0x01, when the latch is set, stores data bits 2 to 6 into the status byte; data bits 0, 1 and 7 are ignored. Without the latch set, the command is ignored.
- R10: If chip select rises in the middle of a byte, the partial byte is discarded and the array is unchanged by it.
- R11: An unknown command byte changes nothing, and MISO stays low for the rest of its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select framing each command |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, low when idle |

## Verification
The bench drives streams that cross the top of the array and cross a page boundary with rollover set. A design with the two wrap modes swapped would return bytes from the wrong page or from past the end of the array. Writes are attempted without the latch set, and after the latch was set and then cleared. Any leak would show up as a changed byte on readback. A frame is cut off four bits into a data byte; a design that commits partial bytes would corrupt the next location. Status writes with all ones check that the busy bit, the latch and bit7 cannot be forced.

// File: rtl/eeram_pkg.sv
package eeram_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam int PAGE_BITS = 5;

  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_DATA, PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_front.sv
module spi_front (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  logic [2:0] sclk_q;
  logic [1:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign sclk_fall = ~sclk_q[1] & sclk_q[2];
  assign cs_act    = ~cs_q[1];
  assign mosi_s    = mosi_q[1];
endmodule

// File: rtl/eeram_mem.sv
module eeram_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/eeram_ctrl.sv
module eeram_ctrl
  import eeram_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          cs_act,
  input  logic          mosi_s,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          miso
);
  localparam int HI_W = AW - 8;

  logic [2:0]      bit_cnt, bit_cnt_n;
  logic [6:0]      rx_sh, rx_sh_n;
  phase_t          phase, phase_n;
  logic [7:0]      op, op_n;
  logic [HI_W-1:0] ahi, ahi_n;
  logic [AW-1:0]   addr, addr_n;
  logic            wr_ok, wr_ok_n;
  logic            wel, wel_n;
  logic [4:0]      opt, opt_n;
  logic [7:0]      tx_sh, tx_sh_n;
  logic            miso_q, miso_n;

  logic            byte_done;
  logic [7:0]      rx_byte;
  logic [AW-1:0]   step_addr;
  logic [7:0]      status;
  logic            rollover;

  assign byte_done = cs_act & sclk_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi_s};
  assign rollover  = opt[3];
  assign status    = {1'b0, opt, wel, 1'b0};

  generate
    if (AW > PAGE_BITS) begin : g_paged
      assign step_addr = rollover ?
        {addr[AW-1:PAGE_BITS], addr[PAGE_BITS-1:0] + 1'b1} : addr + 1'b1;
    end else begin : g_flat
      assign step_addr = addr + 1'b1;
    end
  endgenerate

  assign mem_raddr = (phase == PH_ALO) ? {ahi, rx_byte} : step_addr;
  assign mem_we    = byte_done & (phase == PH_DATA) & (op == OP_WRITE) & wr_ok;
  assign mem_waddr = addr;
  assign mem_wdata = rx_byte;
  assign miso      = miso_q;

  always_comb begin
    bit_cnt_n = bit_cnt;
    rx_sh_n   = rx_sh;
    phase_n   = phase;
    op_n      = op;
    ahi_n     = ahi;
    addr_n    = addr;
    wr_ok_n   = wr_ok;
    wel_n     = wel;
    opt_n     = opt;
    tx_sh_n   = tx_sh;
    miso_n    = miso_q;
    if (!cs_act) begin
      bit_cnt_n = '0;
      phase_n   = PH_CMD;
      tx_sh_n   = '0;
      miso_n    = 1'b0;
      if (wr_ok) wel_n = 1'b0;
      wr_ok_n   = 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_sh_n   = rx_byte[6:0];
        bit_cnt_n = bit_cnt + 3'd1;
      end
      if (sclk_fall) begin
        miso_n  = tx_sh[7];
        tx_sh_n = {tx_sh[6:0], 1'b0};
      end
      if (byte_done) begin
        tx_sh_n = '0;
        unique case (phase)
          PH_CMD: begin
            op_n = rx_byte;
            case (rx_byte)
              OP_WREN:  begin wel_n = 1'b1; phase_n = PH_SKIP; end
              OP_WRDI:  begin wel_n = 1'b0; phase_n = PH_SKIP; end
              OP_WRITE: begin wr_ok_n = wel; phase_n = PH_AHI; end
              OP_READ:  phase_n = PH_AHI;
              OP_WRSR:  begin wr_ok_n = wel; phase_n = PH_DATA; end
              OP_RDSR:  begin tx_sh_n = status; phase_n = PH_DATA; end
              default:  phase_n = PH_SKIP;
            endcase
          end
          PH_AHI: begin
            ahi_n   = rx_byte[HI_W-1:0];
            phase_n = PH_ALO;
          end
          PH_ALO: begin
            addr_n  = {ahi, rx_byte};
            phase_n = PH_DATA;
            if (op == OP_READ) tx_sh_n = mem_rdata;
          end
          PH_DATA: begin
            case (op)
              OP_WRITE: addr_n = step_addr;
              OP_READ:  begin addr_n = step_addr; tx_sh_n = mem_rdata; end
              OP_WRSR:  begin
                if (wr_ok) opt_n = rx_byte[6:2];
                phase_n = PH_SKIP;
              end
              default:  tx_sh_n = status;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      phase   <= PH_CMD;
      op      <= '0;
      ahi     <= '0;
      addr    <= '0;
      wr_ok   <= 1'b0;
      wel     <= 1'b0;
      opt     <= '0;
      tx_sh   <= '0;
      miso_q  <= 1'b0;
    end else begin
      bit_cnt <= bit_cnt_n;
      rx_sh   <= rx_sh_n;
      phase   <= phase_n;
      op      <= op_n;
      ahi     <= ahi_n;
      addr    <= addr_n;
      wr_ok   <= wr_ok_n;
      wel     <= wel_n;
      opt     <= opt_n;
      tx_sh   <= tx_sh_n;
      miso_q  <= miso_n;
    end
  end

  AST_WREN_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_CMD && rx_byte == OP_WREN) |=> wel); // R3
  AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && wr_ok) |=> !wel); // R5
  AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wel && cs_act)); // R4
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && (op == OP_WRITE || op == OP_READ) && rollover)
      |=> addr[AW-1:PAGE_BITS] == $past(addr[AW-1:PAGE_BITS])); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> (bit_cnt == 3'd0 && !miso_q)); // R10
endmodule

// File: rtl/sram_spi_target.sv
module sram_spi_target #(
  parameter int ARR_AW = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic [1:0] rst_q;
  logic       rst_core_n;
  logic       sclk_rise, sclk_fall, cs_act, mosi_s;
  logic       mem_we;
  logic [ARR_AW-1:0] mem_waddr, mem_raddr;
  logic [7:0] mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  spi_front u_front (
    .clk(clk), .rst_n(rst_core_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  eeram_ctrl #(.AW(ARR_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_s(mosi_s), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .miso(miso)
  );

  eeram_mem #(.AW(ARR_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: tb/sim_sram_spi_target.sv
module sim_sram_spi_target;
  localparam int AW = 11;
  localparam int MASK = (1 << AW) - 1;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int tests = 0;
  int fails = 0;
  int idle_bad = 0;
  int cs_hi_cnt = 0;
  bit done = 1'b0;

  logic [7:0] ref_mem [int];
  logic [7:0] ref_opt = 8'h00;
  bit ref_wel = 1'b0;
  logic [7:0] q [$];

  always #5 clk = ~clk;

  sram_spi_target #(.ARR_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  // R1: MISO low while chip select has been high for a while, every clock
  always @(negedge clk) begin
    if (cs_n) cs_hi_cnt <= cs_hi_cnt + 1; else cs_hi_cnt <= 0;
    if (rst_n && cs_n && cs_hi_cnt > 4 && miso !== 1'b0) idle_bad <= idle_bad + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return (ref_opt & 8'h7C) | {6'b0, ref_wel, 1'b0};
  endfunction

  function automatic int m_next(input int a);
    if (ref_opt[5]) return (a & ~31) | ((a + 1) & 31);
    return (a + 1) & MASK;
  endfunction

  task automatic xfer_bit(input logic b, output logic got);
    mosi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    got = miso;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  // Sends q as one frame plus part_bits of part_val, compares MISO with the model
  task automatic frame(input string tag, input int part_bits = 0, input logic [7:0] part_val = 8'h00);
    logic [7:0] op = 8'h00;
    logic [7:0] ahi = 8'h00;
    bit wr_ok = 1'b0;
    int addr = 0;
    logic got;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < q.size(); i++) begin
      logic [7:0] rx = 8'h00;
      logic [7:0] exp = 8'h00;
      if (i > 0 && op == 8'h05) exp = m_status();
      else if (i >= 3 && op == 8'h03) exp = ref_mem[addr];
      for (int k = 7; k >= 0; k--) begin
        xfer_bit(q[i][k], got);
        rx[k] = got;
      end
      check(rx === exp, tag, rx, exp);
      if (i == 0) begin
        op = q[0];
        if (op == 8'h06) ref_wel = 1'b1;
        if (op == 8'h04) ref_wel = 1'b0;
        if (op == 8'h02 || op == 8'h01) wr_ok = ref_wel;
      end else if (op == 8'h01) begin
        if (i == 1 && wr_ok) ref_opt = q[1] & 8'h7C;
      end else if (op == 8'h02 || op == 8'h03) begin
        if (i == 1) ahi = q[1];
        else if (i == 2) addr = {ahi, q[2]} & MASK;
        else begin
          if (op == 8'h02 && wr_ok) ref_mem[addr] = q[i];
          addr = m_next(addr);
        end
      end
    end
    for (int k = 7; k > 7 - part_bits; k--) xfer_bit(part_val[k], got);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    if (wr_ok) ref_wel = 1'b0;
    repeat (3 * HALF) @(negedge clk);
    q.delete();
  endtask

  task automatic wren();
    q = '{8'h06};
    frame("R3 wren");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    q = '{8'h05, 8'h00, 8'h00};              frame("R1 R2 status after reset");
    wren();
    q = '{8'h05, 8'h00};                     frame("R3 status shows latch");
    q = '{8'h02, 8'h00, 8'h10, 8'h11, 8'h22, 8'h33}; frame("R4 write without latch");
    wren();
    q = '{8'h02, 8'h00, 8'h10, 8'h11, 8'h22, 8'h33}; frame("R4 write");
    q = '{8'h05, 8'h00};                     frame("R5 latch cleared after write");
    q = '{8'h03, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00}; frame("R6 read stream");
    q = '{8'h02, 8'h00, 8'h10, 8'h99};       frame("R4 no latch ignored");
    q = '{8'h03, 8'h00, 8'h10, 8'h00};       frame("R4 readback unchanged");
    wren();
    q = '{8'h02, 8'hF8, 8'h12, 8'h44};       frame("R4 masked address write");
    q = '{8'h03, 8'h00, 8'h12, 8'h00};       frame("R4 masked address read");
    wren();
    q = '{8'h02, 8'h07, 8'hFF, 8'hA1, 8'hA2}; frame("R8 write across top");
    q = '{8'h03, 8'h00, 8'h00, 8'h00};       frame("R8 wrapped byte at 0");
    q = '{8'h03, 8'h07, 8'hFF, 8'h00, 8'h00}; frame("R8 read across top");
    wren();
    q = '{8'h02, 8'h00, 8'h50, 8'h5A, 8'h5B}; frame("R10 prefill");
    wren();
    q = '{8'h02, 8'h00, 8'h50, 8'hC1};       frame("R10 aborted frame", 4, 8'hEE);
    q = '{8'h03, 8'h00, 8'h50, 8'h00, 8'h00}; frame("R10 partial byte dropped");
    wren();
    q = '{8'h04};                            frame("R3 wrdi");
    q = '{8'h02, 8'h00, 8'h50, 8'h77};       frame("R3 write after wrdi");
    q = '{8'h03, 8'h00, 8'h50, 8'h00};       frame("R3 readback after wrdi");
    wren();
    q = '{8'h01, 8'hFF};                     frame("R9 status write all ones");
    q = '{8'h05, 8'h00, 8'h00};              frame("R9 R2 stored option bits");
    q = '{8'h01, 8'h20};                     frame("R9 status write no latch");
    q = '{8'h05, 8'h00};                     frame("R9 status unchanged");
    wren();
    q = '{8'h01, 8'h20};                     frame("R9 set rollover");
    q = '{8'h05, 8'h00};                     frame("R9 rollover only");
    wren();
    q = '{8'h02, 8'h00, 8'h3E, 8'hB0, 8'hB1, 8'hB2, 8'hB3}; frame("R7 write across page");
    q = '{8'h03, 8'h00, 8'h20, 8'h00, 8'h00}; frame("R7 wrapped within page");
    q = '{8'h03, 8'h00, 8'h3F, 8'h00, 8'h00}; frame("R7 read wraps in page");
    q = '{8'h9F, 8'h00, 8'h00};              frame("R11 unknown command");
    q = '{8'h05, 8'h00};                     frame("R11 status unchanged");

    check(idle_bad == 0, "R1 idle MISO low", 8'(idle_bad), 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule